// File: doc/BRIEF.md
# Routable Interrupt Multiplexer Controller

This block collects nine level-sensitive interrupt sources from peripheral logic and steers them onto three active-low request lines that run to a host processor's interrupt controller. Each source passes through a two-flop synchroniser. It is then normalised to an internal active-high form. Sources 1 and 8 are wired as active high and source 2 as active low. The other six sources follow a polarity register that software sets.

Each request line has its own 32-bit word. The low field of that word holds the enable mask for the line. The upper field holds the pending flags for the line and acknowledges them on a write of ones. Software routes a source by enabling it in the word of the chosen line. When a request line goes low, the handler reads that line's word, services the highest-numbered pending source, and writes a one to its pending bit. The register port is a plain synchronous port. A write takes effect on the clock edge where `bus_wr_en` is high. Read data is combinational from `bus_addr`. Every access moves a whole 32-bit word, and bit 0 is the least significant bit of the word.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, all enable and pending bits are 0, every `irq_n` output is high, and the polarity word at byte offset 0x0 reads 0x0000_0102, because the fixed-high sources 1 and 8 read as 1 and the other sources start active low.
- R2: In the polarity word at offset 0x0, bit n = 1 makes source n active high and bit n = 0 makes it active low, for n in {0,3,4,5,6,7}. Bits 1 and 8 always read 1 and bit 2 always reads 0, and writes to these three bits have no effect on how the sources behave.
- R3: A level change on `src_raw` passes through two synchroniser flops. If the change is applied before clock edge k, its pending bit is set on edge k+2 and `irq_n` falls after edge k+2, not earlier.
- R4: Line L (0..2) has its word at byte offset 0x4 + 4·L. Bits 8:0 are the enable mask and bits 24:16 are the pending flags, with source n at bit n+16. A pending bit is set only when its source is active and enabled in that line's word.
- R5: Writing 1 to bit n+16 of a line word clears pending bit n on that edge. If the source is still active and enabled, the bit is set again on the next edge. Writing 0 to a pending bit leaves it unchanged.
- R6: `irq_n[L]` is low exactly while some pending bit of line L has its enable bit set. Clearing the enable releases the line but keeps the pending bit.
- R7: Bits 15:9 and 31:25 of every word read 0 and ignore writes. Reads of any byte offset other than 0x0, 0x4, 0x8 and 0xC return 0.
- R8: Lines are independent. A source that is enabled on several lines pends on each of them, and an acknowledge on one line does not touch the others.
- R9: A pending bit stays set after its source goes inactive, until software acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_raw | input | 9 | Raw interrupt source levels, one bit per source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_n | output | 3 | Active-low request lines to the host |

## Verification
The main routing path is swept over all nine sources, both settings of the polarity word, and both raw input levels. Each source is enabled alone on line n mod 3. This sweep separates the configurable polarities from the three fixed ones, shows that a write to a fixed bit is ignored, and checks that only the target line asserts. Further directed sequences measure the synchroniser latency edge by edge. They also tell apart the set-again-after-acknowledge case, the writing-zero case and the sticky-after-deassert case. A single source enabled on all three lines shows that each line keeps its own pending state.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NUM_SRC   = 9;
  localparam int unsigned NUM_LINE  = 3;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned PEND_LSB  = 16;
  localparam int unsigned LINE_STEP = 4;
  // Sources whose sense is hard-wired, and their level (1 = active high)
  localparam logic [NUM_SRC-1:0] FIXED_SEL  = 9'b1_0000_0110;
  localparam logic [NUM_SRC-1:0] FIXED_HIGH = 9'b1_0000_0010;
endpackage

// File: rtl/irq_sync_2ff.sv
module irq_sync_2ff #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/irq_polarity_norm.sv
module irq_polarity_norm #(
  parameter int unsigned   N          = 9,
  parameter logic [N-1:0]  FIXED_SEL  = '0,
  parameter logic [N-1:0]  FIXED_HIGH = '0
) (
  input  logic [N-1:0] lvl_sync,
  input  logic [N-1:0] pol_cfg,
  output logic [N-1:0] pol_eff,
  output logic [N-1:0] active
);
  // Fixed-sense sources override the software setting
  for (genvar i = 0; i < N; i++) begin : g_src
    if (FIXED_SEL[i]) begin : g_fixed
      assign pol_eff[i] = FIXED_HIGH[i];
    end else begin : g_cfg
      assign pol_eff[i] = pol_cfg[i];
    end
    assign active[i] = ~(lvl_sync[i] ^ pol_eff[i]);
  end
endmodule

// File: rtl/irq_line_unit.sv
module irq_line_unit #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [N-1:0] wr_en_bits,
  input  logic [N-1:0] wr_ack_bits,
  input  logic [N-1:0] src_active,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pend_q,
  output logic         req
);
  logic [N-1:0] ack_now;
  logic [N-1:0] pend_d;

  assign ack_now = wr_hit ? wr_ack_bits : '0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (ack_now[i]) pend_d[i] = 1'b0;
      else            pend_d[i] = pend_q[i] | (src_active[i] & en_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_hit) en_q <= wr_en_bits;
    end
  end

  assign req = |(pend_q & en_q);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned N_LINE = NUM_LINE,
  parameter int unsigned ADDR_W = 8,
  parameter logic [N_SRC-1:0] FIX_SEL  = FIXED_SEL,
  parameter logic [N_SRC-1:0] FIX_HIGH = FIXED_HIGH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    src_raw,
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic [N_LINE-1:0]   irq_n
);
  localparam logic [ADDR_W-1:0] POL_ADDR = '0;

  logic [N_SRC-1:0]              src_sync;
  logic [N_SRC-1:0]              pol_q;
  logic [N_SRC-1:0]              pol_eff;
  logic [N_SRC-1:0]              src_active;
  logic [N_LINE-1:0][N_SRC-1:0]  line_en;
  logic [N_LINE-1:0][N_SRC-1:0]  line_pend;
  logic [N_LINE-1:0]             line_req;
  logic                          wdata_unused;

  assign wdata_unused = ^bus_wdata;

  irq_sync_2ff #(.W(N_SRC)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (src_raw),
    .d_sync  (src_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                pol_q <= '0;
    else if (bus_wr_en && bus_addr == POL_ADDR) pol_q <= bus_wdata[N_SRC-1:0];
  end

  irq_polarity_norm #(
    .N          (N_SRC),
    .FIXED_SEL  (FIX_SEL),
    .FIXED_HIGH (FIX_HIGH)
  ) norm_i (
    .lvl_sync (src_sync),
    .pol_cfg  (pol_q),
    .pol_eff  (pol_eff),
    .active   (src_active)
  );

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(LINE_STEP * (l + 1));
    logic hit;
    assign hit = bus_wr_en && (bus_addr == MY_ADDR);

    irq_line_unit #(.N(N_SRC)) line_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (hit),
      .wr_en_bits  (bus_wdata[N_SRC-1:0]),
      .wr_ack_bits (bus_wdata[PEND_LSB +: N_SRC]),
      .src_active  (src_active),
      .en_q        (line_en[l]),
      .pend_q      (line_pend[l]),
      .req         (line_req[l])
    );
    assign irq_n[l] = ~line_req[l];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == POL_ADDR) bus_rdata[N_SRC-1:0] = pol_eff;
    for (int l = 0; l < N_LINE; l++) begin
      if (bus_addr == ADDR_W'(LINE_STEP * (l + 1))) begin
        bus_rdata[N_SRC-1:0]          = line_en[l];
        bus_rdata[PEND_LSB +: N_SRC]  = line_pend[l];
      end
    end
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned N_LINE = NUM_LINE,
  parameter int unsigned ADDR_W = 8,
  parameter logic [N_SRC-1:0] FIX_SEL  = FIXED_SEL,
  parameter logic [N_SRC-1:0] FIX_HIGH = FIXED_HIGH
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr_en,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [WORD_W-1:0]         bus_wdata,
  input logic [WORD_W-1:0]         bus_rdata,
  input logic [N_LINE-1:0]         irq_n,
  input logic [N_LINE-1:0][N_SRC-1:0] line_en,
  input logic [N_LINE-1:0][N_SRC-1:0] line_pend
);
  localparam logic [WORD_W-1:0] LIVE_BITS =
    (WORD_W'((1 << N_SRC) - 1)) | (WORD_W'((1 << N_SRC) - 1) << PEND_LSB);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE_BITS) == '0); // R7

  AST_FIXED_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> ((bus_rdata[N_SRC-1:0] & FIX_SEL) == FIX_HIGH)); // R2

  for (genvar l = 0; l < N_LINE; l++) begin : g_l
    localparam logic [ADDR_W-1:0] LA = ADDR_W'(LINE_STEP * (l + 1));

    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en[l] == '0) |-> irq_n[l]); // R6

    for (genvar n = 0; n < N_SRC; n++) begin : g_n
      AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pend[l][n]) |-> $past(line_en[l][n])); // R4

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == LA && bus_wdata[PEND_LSB+n]) |=> !line_pend[l][n]); // R5

      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pend[l][n] && !(bus_wr_en && bus_addr == LA && bus_wdata[PEND_LSB+n]))
          |=> line_pend[l][n]); // R9
    end
  end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .N_SRC    (N_SRC),
  .N_LINE   (N_LINE),
  .ADDR_W   (ADDR_W),
  .FIX_SEL  (FIX_SEL),
  .FIX_HIGH (FIX_HIGH)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_n     (irq_n),
  .line_en   (line_en),
  .line_pend (line_pend)
);

// File: tb/irq_route_ctrl_tb_top.sv
module irq_route_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_raw = '0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz, 20 ns period

  irq_route_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_raw   (src_raw),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic reg_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #2;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input logic [2:0] exp, input string req);
    check(irq_n === exp, req, {29'd0, irq_n}, {29'd0, exp});
  endtask

  task automatic clear_all();
    for (int l = 0; l < 3; l++) reg_wr(8'(4 * (l + 1)), 32'h01FF_0000);
  endtask

  function automatic bit eff_high(input int n, input bit p);
    if (n == 1 || n == 8) return 1'b1;
    if (n == 2) return 1'b0;
    return p;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_chk(8'h00, 32'h0000_0102, "R1 polarity reset");
    reg_chk(8'h04, 32'h0, "R1 line0 reset");
    reg_chk(8'h08, 32'h0, "R1 line1 reset");
    reg_chk(8'h0C, 32'h0, "R1 line2 reset");
    irq_chk(3'b111, "R1 irq_n reset");

    // R7: unmapped offsets read zero
    reg_chk(8'h10, 32'h0, "R7 unmapped 0x10");
    reg_chk(8'h02, 32'h0, "R7 unmapped 0x02");
    reg_chk(8'h40, 32'h0, "R7 unmapped 0x40");
    reg_chk(8'hFC, 32'h0, "R7 unmapped 0xFC");

    // R2 R4 R6: sweep of source x polarity x level
    for (int n = 0; n < 9; n++) begin
      for (int p = 0; p < 2; p++) begin
        for (int r = 0; r < 2; r++) begin
          int  ln;
          bit  act;
          logic [31:0] pw;
          ln = n % 3;
          pw = p ? 32'hFFFF_FFFF : 32'h0;
          src_raw = r ? 9'h1FF : 9'h000;
          reg_wr(8'h00, pw);
          if (r == 0)
            reg_chk(8'h00, (pw & 32'h0F9) | 32'h102, "R2 polarity readback");
          repeat (3) @(negedge clk);
          clear_all();
          reg_wr(8'(4 * (ln + 1)), 32'(1) << n);
          @(negedge clk);
          act = (r[0] == eff_high(n, p[0]));
          reg_chk(8'(4 * (ln + 1)), (32'(act) << (16 + n)) | (32'(1) << n), "R2 R4 pending by polarity");
          irq_chk(act ? ~(3'b001 << ln) : 3'b111, "R6 irq by line");
        end
      end
    end

    // R7: reserved bits ignore writes
    src_raw = '0;
    reg_wr(8'h04, 32'hFFFF_FFFF);
    reg_chk(8'h04, 32'h0000_01FF, "R7 reserved bits of line word");
    clear_all();

    // R3: synchroniser latency
    reg_wr(8'h00, 32'h1FF);
    repeat (3) @(negedge clk);
    clear_all();
    reg_wr(8'h04, 32'h1);
    src_raw[0] = 1'b1;
    @(negedge clk);
    irq_chk(3'b111, "R3 no irq after first edge");
    @(negedge clk);
    irq_chk(3'b111, "R3 no irq after second edge");
    @(negedge clk);
    irq_chk(3'b110, "R3 irq after third edge");
    reg_chk(8'h04, 32'h0001_0001, "R3 pending after third edge");

    // R9: sticky after deassert
    src_raw[0] = 1'b0;
    repeat (4) @(negedge clk);
    reg_chk(8'h04, 32'h0001_0001, "R9 sticky pending");
    irq_chk(3'b110, "R9 irq held");
    // R5: zero write no effect, one write clears
    reg_wr(8'h04, 32'h0000_0001);
    reg_chk(8'h04, 32'h0001_0001, "R5 zero ack ignored");
    reg_wr(8'h04, 32'h0001_0001);
    reg_chk(8'h04, 32'h0000_0001, "R5 ack clears");
    irq_chk(3'b111, "R5 irq released");
    // R5: re-set after ack while still active
    src_raw[0] = 1'b1;
    repeat (3) @(negedge clk);
    reg_chk(8'h04, 32'h0001_0001, "R5 pending again");
    reg_wr(8'h04, 32'h0001_0001);
    reg_chk(8'h04, 32'h0000_0001, "R5 cleared on ack edge");
    @(negedge clk);
    reg_chk(8'h04, 32'h0001_0001, "R5 set again next edge");

    // R6: disabling releases line but keeps pending
    reg_wr(8'h04, 32'h0);
    reg_chk(8'h04, 32'h0001_0000, "R6 pending kept when disabled");
    irq_chk(3'b111, "R6 line released when disabled");
    reg_wr(8'h04, 32'h1);
    irq_chk(3'b110, "R6 line asserted on re-enable");

    // R8: one source on all three lines
    src_raw = '0;
    repeat (3) @(negedge clk);
    clear_all();
    src_raw[4] = 1'b1;
    repeat (3) @(negedge clk);
    reg_wr(8'h04, 32'h10);
    reg_wr(8'h08, 32'h10);
    reg_wr(8'h0C, 32'h10);
    @(negedge clk);
    irq_chk(3'b000, "R8 all lines asserted");
    src_raw[4] = 1'b0;
    repeat (3) @(negedge clk);
    reg_wr(8'h08, 32'h0010_0010);
    reg_chk(8'h08, 32'h0000_0010, "R8 line1 acked");
    reg_chk(8'h04, 32'h0010_0010, "R8 line0 untouched");
    reg_chk(8'h0C, 32'h0010_0010, "R8 line2 untouched");
    irq_chk(3'b010, "R8 only line1 released");

    finish_run();
  end
endmodule